// File: doc/BRIEF.md
# Floating-Point Multiply Exception-Flag Unit

This block takes two IEEE single-precision operands and reports only the IEEE exception flags that their product would raise. It never delivers the product value. The result is a 32-bit integer flag word. A write-enable and a destination tag come with it, and all three arrive a fixed three cycles after the operands are issued. A guard bit decides whether the destination is written at all. A 2-bit rounding-mode input steers the rounding decision, and that decision sets the inexact, overflow and underflow flags.

Denormal operands are replaced by a zero of the same sign before the multiply, and a separate input-flush flag records that this happened. A product that is tiny before rounding always raises underflow and inexact. An output-flush flag is added only when the product, rounded to denormal precision, is a nonzero value below the smallest normal. Infinities, zeros and NaNs are settled by a dedicated decode path that runs beside the significand multiplier.

Top module: `fmf_mulflags`

## Requirements
- R1: Flag positions in `out_flags` are: bit0 divide-by-zero, bit1 inexact (INX), bit2 underflow (UNF), bit3 overflow (OVF), bit4 invalid (INV), bit5 input flushed (IFZ), bit6 output flushed (OFZ). Bits 31..7 are always zero, and bit0 is never set.
- R2: Operands presented in cycle t produce `out_wen`, `out_flags` and `out_tag` in cycle t+3. `out_tag` equals the issued `in_tag`.
- R3: `out_wen` is 1 only for an issue with `in_valid`=1 and `in_guard`=1. Whenever `out_wen` is 0, `out_flags` is 0.
- R4: An operand with exponent field 0 and a nonzero fraction is treated as a zero of its own sign and sets IFZ (3.0 × 0x00400000 gives 0x20). IFZ is added on top of any other outcome.
- R5: A product of normal numbers that is exactly representable as a normal number gives 0 (for example 3.0 × -3.0).
- R6: `in_rmode` selects rounding: 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero. A product that is not exactly representable sets INX.
- R7: A product whose rounded magnitude exceeds the largest finite number sets OVF and INX in every rounding mode (0x7F7FFFFF squared gives 0x0A).
- R8: A finite nonzero product below 2^-126 before rounding sets UNF and INX. OFZ is added when its value rounded to a multiple of 2^-149 is nonzero and below 2^-126 (0.5 × 0x00800000 gives 0x46, while 0x00800000 squared under nearest-even gives 0x06).
- R9: Infinity times zero (including a flushed denormal) sets INV. Infinity times infinity or times a finite nonzero number sets no flags.
- R10: A NaN operand (exponent 255, nonzero fraction) takes priority over every other case. It gives INV when fraction bit 22 is 0 (signalling) and no flags when that bit is 1 (quiet).
- R11: A new operation can be issued in every cycle. Each result depends only on its own issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| in_guard | input | 1 | Guard bit; destination written only when 1 |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 +inf, 10 -inf, 11 zero) |
| in_a | input | 32 | First single-precision operand |
| in_b | input | 32 | Second single-precision operand |
| in_tag | input | TAG_W | Destination tag carried alongside the operation |
| out_wen | output | 1 | Destination write-enable |
| out_flags | output | 32 | Exception flag word |
| out_tag | output | TAG_W | Destination tag of the delivered result |

## Verification
Each result (write-enable, flag word and tag) is due three cycles after the cycle in which its operands were held on the inputs. Operands are registered at the first rising edge, and the result is visible after the third. The bench keeps a three-slot queue of expected results. The queue advances on every rising edge and is filled from the inputs seen at that edge. Outputs are compared against the last slot at each falling edge. Operations are issued back to back, so any slip of one cycle in the pipeline shows up as a mismatch at once.

// File: rtl/fmf_pkg.sv
package fmf_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int OP_W    = EXP_W + FRAC_W + 1;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int ESUM_W  = EXP_W + 3;

  // flag positions in the result word
  localparam int NFL    = 7;
  localparam int FL_DBZ = 0;
  localparam int FL_INX = 1;
  localparam int FL_UNF = 2;
  localparam int FL_OVF = 3;
  localparam int FL_INV = 4;
  localparam int FL_IFZ = 5;
  localparam int FL_OFZ = 6;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_POS  = 2'b01,
    RM_NEG  = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic              sign;
    logic              zero;    // exponent field 0 (true zero or flushed)
    logic              denorm;
    logic              inf;
    logic              qnan;
    logic              snan;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;     // hidden bit included, 0 for flushed
  } opcls_t;

  // decide whether the magnitude is bumped by one unit in the last place
  function automatic logic round_up(input rmode_e rm, input logic sign,
                                    input logic lsb, input logic g,
                                    input logic s);
    logic r;
    case (rm)
      RM_NEAR: r = g & (s | lsb);
      RM_POS:  r = ~sign & (g | s);
      RM_NEG:  r = sign & (g | s);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fmf_classify.sv
module fmf_classify
  import fmf_pkg::*;
(
  input  logic [OP_W-1:0] word,
  output opcls_t          cls
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              e_lo;
  logic              e_hi;

  always_comb begin
    e          = word[FRAC_W +: EXP_W];
    f          = word[FRAC_W-1:0];
    e_lo       = (e == '0);
    e_hi       = (e == '1);
    cls.sign   = word[OP_W-1];
    cls.exp    = e;
    cls.zero   = e_lo;
    cls.denorm = e_lo & (f != '0);
    cls.inf    = e_hi & (f == '0);
    cls.qnan   = e_hi & f[FRAC_W-1];
    cls.snan   = e_hi & ~f[FRAC_W-1] & (f != '0);
    cls.sig    = e_lo ? '0 : {1'b1, f};
  end
endmodule

// File: rtl/fmf_special.sv
module fmf_special
  import fmf_pkg::*;
(
  input  logic [1:0]     zero,
  input  logic [1:0]     denorm,
  input  logic [1:0]     inf,
  input  logic [1:0]     qnan,
  input  logic [1:0]     snan,
  output logic           settled,
  output logic [NFL-1:0] flags
);
  logic any_nan;

  always_comb begin
    any_nan        = |(qnan | snan);
    flags          = '0;
    flags[FL_IFZ]  = |denorm;
    settled        = any_nan | (|inf) | (|zero);
    if (any_nan)
      flags[FL_INV] = |snan;
    else if (|inf)
      flags[FL_INV] = |zero;
  end
endmodule

// File: rtl/fmf_round.sv
module fmf_round
  import fmf_pkg::*;
(
  input  logic [PROD_W-1:0]        prod,
  input  logic signed [ESUM_W-1:0] esum,
  input  logic                     sign,
  input  rmode_e                   rm,
  output logic [NFL-1:0]           flags,
  output logic                     ev_tiny,
  output logic                     ev_ovf
);
  localparam int SH_BASE = PROD_W - SIG_W + 1;
  localparam int SH_CAP  = PROD_W + 1;
  localparam int SH_W    = $clog2(SH_CAP + 1);
  localparam int WW      = PROD_W + 2;

  logic                     top;
  logic [PROD_W-1:0]        norm;
  logic signed [ESUM_W-1:0] e_n;
  logic signed [ESUM_W-1:0] e_f;
  logic [SIG_W-1:0]         kept;
  logic                     g_n, s_n, inc_n, carry;
  logic                     ovf;
  logic signed [ESUM_W-1:0] sh_full;
  logic [SH_W-1:0]          sh;
  logic [WW-1:0]            nw, qd, qr;
  logic                     g_d, s_d, inc_d, ofz;

  always_comb begin
    top   = prod[PROD_W-1];
    norm  = top ? prod : (prod << 1);
    e_n   = esum + $signed({{(ESUM_W-1){1'b0}}, top});

    // normal-range rounding to SIG_W bits
    kept  = norm[PROD_W-1 -: SIG_W];
    g_n   = norm[PROD_W-SIG_W-1];
    s_n   = |norm[PROD_W-SIG_W-2:0];
    inc_n = round_up(rm, sign, kept[0], g_n, s_n);
    carry = (&kept) & inc_n;
    e_f   = e_n + $signed({{(ESUM_W-1){1'b0}}, carry});
    ovf   = (e_f >= ESUM_W'(EXP_MAX));

    // denormal-precision rounding for tiny products
    ev_tiny = (e_n < ESUM_W'(1));
    sh_full = ESUM_W'(SH_BASE) - e_n;
    if (sh_full > ESUM_W'(SH_CAP))
      sh = SH_W'(SH_CAP);
    else if (sh_full < ESUM_W'(1))
      sh = SH_W'(1);
    else
      sh = sh_full[SH_W-1:0];
    nw    = {2'b00, norm};
    qd    = nw >> sh;
    g_d   = |(nw & (WW'(1) << (sh - 1)));
    s_d   = |(nw & ((WW'(1) << (sh - 1)) - WW'(1)));
    inc_d = round_up(rm, sign, qd[0], g_d, s_d);
    qr    = qd + WW'(inc_d);
    ofz   = (qr != '0) && (qr < (WW'(1) << (SIG_W - 1)));

    ev_ovf = ~ev_tiny & ovf;
    flags  = '0;
    if (ev_tiny) begin
      flags[FL_UNF] = 1'b1;
      flags[FL_INX] = 1'b1;
      flags[FL_OFZ] = ofz;
    end else if (ovf) begin
      flags[FL_OVF] = 1'b1;
      flags[FL_INX] = 1'b1;
    end else begin
      flags[FL_INX] = g_n | s_n;
    end
  end
endmodule

// File: rtl/fmf_mulflags.sv
module fmf_mulflags
  import fmf_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_guard,
  input  logic [1:0]       in_rmode,
  input  logic [OP_W-1:0]  in_a,
  input  logic [OP_W-1:0]  in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_wen,
  output logic [OUT_W-1:0] out_flags,
  output logic [TAG_W-1:0] out_tag
);
  localparam int NOPS = 2;

  // operand decode
  logic [OP_W-1:0] ops [NOPS];
  opcls_t          cls [NOPS];
  logic [NOPS-1:0] v_zero, v_den, v_inf, v_qnan, v_snan;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    fmf_classify u_cls (.word(ops[i]), .cls(cls[i]));
    assign v_zero[i] = cls[i].zero;
    assign v_den[i]  = cls[i].denorm;
    assign v_inf[i]  = cls[i].inf;
    assign v_qnan[i] = cls[i].qnan;
    assign v_snan[i] = cls[i].snan;
  end

  logic           spc_settled;
  logic [NFL-1:0] spc_flags;

  fmf_special u_spc (
    .zero(v_zero), .denorm(v_den), .inf(v_inf),
    .qnan(v_qnan), .snan(v_snan),
    .settled(spc_settled), .flags(spc_flags)
  );

  logic [PROD_W-1:0]        prod_c;
  logic signed [ESUM_W-1:0] esum_c;

  assign prod_c = PROD_W'(cls[0].sig) * PROD_W'(cls[1].sig);
  assign esum_c = ESUM_W'(cls[0].exp) + ESUM_W'(cls[1].exp) - ESUM_W'(BIAS);

  // stage 1
  logic                     s1_wen;
  logic [TAG_W-1:0]         s1_tag;
  rmode_e                   s1_rm;
  logic                     s1_sign;
  logic                     s1_settled;
  logic [NFL-1:0]           s1_sflags;
  logic [PROD_W-1:0]        s1_prod;
  logic signed [ESUM_W-1:0] s1_esum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_wen     <= 1'b0;
      s1_tag     <= '0;
      s1_rm      <= RM_NEAR;
      s1_sign    <= 1'b0;
      s1_settled <= 1'b0;
      s1_sflags  <= '0;
      s1_prod    <= '0;
      s1_esum    <= '0;
    end else begin
      s1_wen     <= in_valid & in_guard;
      s1_tag     <= in_tag;
      s1_rm      <= rmode_e'(in_rmode);
      s1_sign    <= cls[0].sign ^ cls[1].sign;
      s1_settled <= spc_settled;
      s1_sflags  <= spc_flags;
      s1_prod    <= prod_c;
      s1_esum    <= esum_c;
    end
  end

  // stage 2: normalise and round
  logic [NFL-1:0] rnd_flags;
  logic           rnd_tiny, rnd_ovf;
  logic           ev_tiny, ev_ovf;
  logic [NFL-1:0] s2_flags_c;

  fmf_round u_rnd (
    .prod(s1_prod), .esum(s1_esum), .sign(s1_sign), .rm(s1_rm),
    .flags(rnd_flags), .ev_tiny(rnd_tiny), .ev_ovf(rnd_ovf)
  );

  assign ev_tiny    = ~s1_settled & rnd_tiny;
  assign ev_ovf     = ~s1_settled & rnd_ovf;
  assign s2_flags_c = s1_settled ? s1_sflags : (s1_sflags | rnd_flags);

  logic             s2_wen;
  logic [TAG_W-1:0] s2_tag;
  logic [NFL-1:0]   s2_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_wen   <= 1'b0;
      s2_tag   <= '0;
      s2_flags <= '0;
    end else begin
      s2_wen   <= s1_wen;
      s2_tag   <= s1_tag;
      s2_flags <= s2_flags_c;
    end
  end

  // stage 3: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_wen   <= 1'b0;
      out_flags <= '0;
      out_tag   <= '0;
    end else begin
      out_wen   <= s2_wen;
      out_flags <= s2_wen ? OUT_W'(s2_flags) : '0;
      out_tag   <= s2_tag;
    end
  end
endmodule

// File: rtl/fmf_mulflags_chk.sv
module fmf_mulflags_chk
  import fmf_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_guard,
  input logic [OP_W-1:0]  in_a,
  input logic [OP_W-1:0]  in_b,
  input logic [TAG_W-1:0] in_tag,
  input logic             out_wen,
  input logic [OUT_W-1:0] out_flags,
  input logic [TAG_W-1:0] out_tag,
  input logic             s1_wen,
  input logic             ev_tiny,
  input logic             ev_ovf
);
  logic den_in;
  assign den_in = ((in_a[FRAC_W +: EXP_W] == '0) && (in_a[FRAC_W-1:0] != '0)) ||
                  ((in_b[FRAC_W +: EXP_W] == '0) && (in_b[FRAC_W-1:0] != '0));

  assert_flag_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flags[OUT_W-1:NFL] == '0) && !out_flags[FL_DBZ]);

  assert_wen_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> $past(in_valid && in_guard, 3));

  assert_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wen |-> (out_flags == '0));

  assert_tag_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> (out_tag == $past(in_tag, 3)));

  assert_input_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen && $past(den_in, 3)) |-> out_flags[FL_IFZ]);

  assert_ovf_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && s1_wen) |=> ##1 (out_flags[FL_OVF] && out_flags[FL_INX]));

  assert_tiny_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tiny && s1_wen) |=> ##1 (out_flags[FL_UNF] && out_flags[FL_INX]));

  assert_ofz_implies_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[FL_OFZ] |-> (out_flags[FL_UNF] && out_flags[FL_INX]));

  assert_inv_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[FL_INV] |-> !(out_flags[FL_OVF] || out_flags[FL_UNF] || out_flags[FL_INX]));
endmodule

bind fmf_mulflags fmf_mulflags_chk #(.TAG_W(TAG_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard(in_guard),
  .in_a(in_a), .in_b(in_b), .in_tag(in_tag), .out_wen(out_wen),
  .out_flags(out_flags), .out_tag(out_tag), .s1_wen(s1_wen),
  .ev_tiny(ev_tiny), .ev_ovf(ev_ovf)
);

// File: tb/tb_fmf_mulflags.sv
module tb_fmf_mulflags;
  localparam int TAG_W = 5;
  localparam int WD_CYCLES = 100000;

  localparam int B_INX = 1, B_UNF = 2, B_OVF = 3, B_INV = 4, B_IFZ = 5, B_OFZ = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_guard = 1'b0;
  logic [1:0]       in_rmode = 2'b00;
  logic [31:0]      in_a = '0;
  logic [31:0]      in_b = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_wen;
  logic [31:0]      out_flags;
  logic [TAG_W-1:0] out_tag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int cur_req  = 0;

  always #10 clk = ~clk;

  fmf_mulflags #(.TAG_W(TAG_W), .OUT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard(in_guard),
    .in_rmode(in_rmode), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .out_wen(out_wen), .out_flags(out_flags), .out_tag(out_tag)
  );

  // reference model: exact product value, then round at the target lsb
  function automatic logic [31:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] rm);
    logic [31:0] f = '0;
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit za = (ea == 0), zb = (eb == 0);
    bit ia = (ea == 255) && (a[22:0] == 0), ib = (eb == 255) && (b[22:0] == 0);
    bit na = (ea == 255) && (a[22:0] != 0), nb = (eb == 255) && (b[22:0] != 0);
    bit sa = na && !a[22], sb = nb && !b[22];
    bit sgn = a[31] ^ b[31];
    longint unsigned p, q, rem, half;
    int msb, ue, drop;
    bit tiny, up;
    if ((za && a[22:0] != 0) || (zb && b[22:0] != 0)) f[B_IFZ] = 1'b1;
    if (na || nb) begin
      if (sa || sb) f[B_INV] = 1'b1;
      return f;
    end
    if (ia || ib) begin
      if (za || zb) f[B_INV] = 1'b1;
      return f;
    end
    if (za || zb) return f;
    p    = {41'd0, 1'b1, a[22:0]} * {41'd0, 1'b1, b[22:0]};
    msb  = p[47] ? 47 : 46;
    ue   = ea + eb - 254 + msb - 46;
    tiny = (ue < -126);
    drop = tiny ? (151 - ea - eb) : (msb - 23);
    if (drop > 60) drop = 60;
    q    = p >> drop;
    rem  = p - (q << drop);
    half = 64'd1 << (drop - 1);
    case (rm)
      2'b00:   up = (rem > half) || ((rem == half) && q[0]);
      2'b01:   up = !sgn && (rem != 0);
      2'b10:   up = sgn && (rem != 0);
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (tiny) begin
      f[B_UNF] = 1'b1;
      f[B_INX] = 1'b1;
      if (q != 0 && q < (64'd1 << 23)) f[B_OFZ] = 1'b1;
    end else begin
      if (q == (64'd1 << 24)) ue = ue + 1;
      if (ue > 127) begin
        f[B_OVF] = 1'b1;
        f[B_INX] = 1'b1;
      end else if (rem != 0) begin
        f[B_INX] = 1'b1;
      end
    end
    return f;
  endfunction

  function automatic string req_name(input int code, input logic [31:0] f);
    case (code)
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: ;
    endcase
    if (f[B_OVF]) return "R7";
    if (f[B_UNF]) return "R8";
    if (f[B_INV]) return "R9";
    if (f[B_IFZ]) return "R4";
    if (f[B_INX]) return "R6";
    return "R11";
  endfunction

  function automatic logic [31:0] gen_op();
    int k = $urandom_range(0, 9);
    logic s = 1'($urandom);
    logic [22:0] fr = 23'($urandom);
    logic [7:0] e;
    case (k)
      0, 1, 2: e = 8'($urandom_range(1, 254));
      3, 4:    e = 8'($urandom_range(200, 254));
      5, 6:    e = 8'($urandom_range(1, 40));
      7: begin
        e  = 8'($urandom_range(100, 127));
        fr = 23'($urandom_range(0, 3)) | (23'($urandom_range(0, 1)) << 22);
      end
      default: begin
        case ($urandom_range(0, 4))
          0: begin e = 8'd0;   fr = '0; end
          1: begin e = 8'd0;   fr = fr | 23'd1; end
          2: begin e = 8'd255; fr = '0; end
          3: begin e = 8'd255; fr[22] = 1'b1; end
          default: begin e = 8'd255; fr[22] = 1'b0; fr = fr | 23'd1; end
        endcase
      end
    endcase
    return {s, e, fr};
  endfunction

  // expected-result pipeline, three slots
  logic        e_wen [3];
  logic [31:0] e_flg [3];
  logic [TAG_W-1:0] e_tag [3];
  int          e_req [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        e_wen[i] <= 1'b0; e_flg[i] <= '0; e_tag[i] <= '0; e_req[i] <= 0;
      end
    end else begin
      for (int i = 2; i > 0; i--) begin
        e_wen[i] <= e_wen[i-1]; e_flg[i] <= e_flg[i-1];
        e_tag[i] <= e_tag[i-1]; e_req[i] <= e_req[i-1];
      end
      e_wen[0] <= in_valid && in_guard;
      e_flg[0] <= ref_flags(in_a, in_b, in_rmode);
      e_tag[0] <= in_tag;
      e_req[0] <= cur_req;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check(out_wen == 1'b0 && out_flags == '0, "R2", "reset state",
              {31'd0, out_wen} | out_flags, 32'd0);
      end else begin
        check(out_flags[31:7] == '0 && !out_flags[0], "R1", "reserved bits",
              out_flags, out_flags & 32'h7E);
        check(out_wen == e_wen[2], "R3", "write enable", 32'(out_wen), 32'(e_wen[2]));
        if (e_wen[2]) begin
          check(out_flags == e_flg[2], req_name(e_req[2], e_flg[2]), "flags",
                out_flags, e_flg[2]);
          check(out_tag == e_tag[2], "R2", "tag", 32'(out_tag), 32'(e_tag[2]));
        end else begin
          check(out_flags == '0, "R3", "flags without write", out_flags, 32'd0);
        end
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                       input logic g, input int req);
    @(negedge clk);
    in_valid = 1'b1; in_guard = g; in_rmode = rm;
    in_a = a; in_b = b; in_tag = in_tag + 1'b1; cur_req = req;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners, issued back to back (R11)
    issue(32'hC0400000, 32'h3F800000, 2'b00, 1'b1, 5);  // -3 * 1 -> 0
    issue(32'h40400000, 32'hC0400000, 2'b00, 1'b1, 5);  // 3 * -3 -> 0
    issue(32'h40400000, 32'h00800000, 2'b00, 1'b0, 5);  // guard 0: no write (R3)
    issue(32'h40400000, 32'h00800000, 2'b00, 1'b1, 5);  // exact normal -> 0
    issue(32'h3F000000, 32'h00800000, 2'b00, 1'b1, 8);  // 0x46
    issue(32'h7F800000, 32'h00000000, 2'b00, 1'b1, 9);  // inf*0 -> INV
    issue(32'h40400000, 32'h00400000, 2'b00, 1'b1, 4);  // denorm -> IFZ
    issue(32'h00C00000, 32'h80800000, 2'b00, 1'b1, 8);  // 0x06
    issue(32'h7F800000, 32'hFF800000, 2'b00, 1'b1, 9);  // inf*-inf -> 0
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b00, 1'b1, 7);  // 0x0A
    issue(32'h00800000, 32'h00800000, 2'b00, 1'b1, 8);  // 0x06
    issue(32'h00800000, 32'h00800000, 2'b01, 1'b1, 8);  // toward +inf -> 0x46
    issue(32'h00800000, 32'h00800000, 2'b10, 1'b1, 6);  // toward -inf -> 0x06
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b11, 1'b1, 7);  // toward zero still 0x0A
    issue(32'h3F800001, 32'h3F800001, 2'b00, 1'b1, 6);  // inexact -> 0x02
    issue(32'h3F800001, 32'h3F800001, 2'b11, 1'b1, 6);  // inexact under RZ
    issue(32'h7FC00000, 32'h3F800000, 2'b00, 1'b1, 10); // quiet NaN -> 0
    issue(32'h7F800001, 32'h3F800000, 2'b00, 1'b1, 10); // signalling NaN -> INV
    issue(32'h7FA00000, 32'h00400000, 2'b00, 1'b1, 10); // sNaN*denorm -> 0x30
    issue(32'h7FC00000, 32'h7F800000, 2'b00, 1'b1, 10); // qNaN beats inf -> 0
    issue(32'h7F800000, 32'h80000001, 2'b00, 1'b1, 9);  // inf*denorm -> 0x30
    issue(32'h4B000000, 32'h3F800000, 2'b01, 1'b1, 11); // exact in every mode
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 9) != 0);
      in_guard = ($urandom_range(0, 7) != 0);
      in_rmode = 2'($urandom);
      in_a     = gen_op();
      in_b     = gen_op();
      in_tag   = TAG_W'($urandom);
      cur_req  = 0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end
endmodule